// File: doc/BRIEF.md
# Same-Cycle Taint Shortcut Filter

This block sits in an in-order taint propagation stage and settles, in the same cycle, the cases where an instruction's output taint state follows from a trivial rule. It keeps a 2-bit policy code for each opcode. For the current instruction it looks up that code, inspects the two register source states and the memory state, and reports whether a shortcut applies. When one does, it also gives the result state. When none does, the instruction goes on to the slower response cache lookup, which lies outside this block.

Two shortcuts exist. The zero rule says that clean inputs produce a clean output. The unary rule says that when exactly one input is tainted, its state passes through unchanged. The all-zero state is always the safe state. An opcode's code turns on the zero rule alone, turns on both rules, or turns off every shortcut. The whole table is reachable through a 32-bit word-addressed configuration port. The operating system reads it out and writes it back as 64 bytes when it switches context.

Top module: `taint_fast_filter`

## Requirements
- R1: After reset every table word reads as zero, so every opcode has code 00 and `hit` is low for any input.
- R2: Configuration word k holds the codes of opcodes 16k to 16k+15. Opcode 16k+j sits in bits [2j+1:2j]. A write takes effect on the next clock edge. `cfg_rdata` always shows the word that `cfg_addr` selects.
- R3: For an opcode with code 00, `hit` is low whatever the states are.
- R4: Code 11 behaves exactly like code 00.
- R5: Under code 01, `hit` is high with `res_st` zero when all effective input states are zero. `hit` is low when any of them is nonzero.
- R6: Under code 10, all-zero inputs give `hit` high with `res_st` zero. Exactly one nonzero effective state gives `hit` high with `res_st` equal to that state. Two or more nonzero states give `hit` low.
- R7: When `mem_use` is low, `mem_st` is treated as zero before the rules apply.
- R8: `res_st` is zero whenever `hit` is low.
- R9: A configuration write changes only the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 8 | Opcode of the instruction being propagated |
| src_a_st | input | 2 | Taint state of first register source |
| src_b_st | input | 2 | Taint state of second register source |
| mem_st | input | 2 | Taint state of the memory word |
| mem_use | input | 1 | Instruction accesses memory |
| hit | output | 1 | Shortcut resolved the result this cycle |
| res_st | output | 2 | Result taint state when `hit` is high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |

## Verification
Opcodes are configured with each of the four codes. Every combination of the three 2-bit states is then swept for one zero-rule opcode and one unary opcode. This separates the all-clean case, the single-taint case and the multi-taint case, and it shows which source the passed-through state comes from. Each single-taint case is also repeated with `mem_use` low and a nonzero memory state. That reveals whether the memory input leaks into the count or the result. Configuration words are read back after writes to the first and last words and to a middle word. This ties each opcode to its bit slot and shows that neighbouring words stay untouched.

// File: rtl/taint_filt_pkg.sv
package taint_filt_pkg;
   localparam int CODE_W = 2;
   localparam int NSRC   = 3;

   typedef enum logic [CODE_W-1:0] {
      FC_OFF   = 2'b00,
      FC_ZERO  = 2'b01,
      FC_UNARY = 2'b10,
      FC_RSV   = 2'b11
   } fcode_e;
endpackage

// File: rtl/taint_filt_table.sv
module taint_filt_table #(
   parameter int OPC_W  = 8,
   parameter int CFG_DW = 32,
   parameter int SLOT_W = 4,
   parameter int ADDR_W = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [CFG_DW-1:0]                   wdata,
   output logic [CFG_DW-1:0]                   rdata,
   input  logic [OPC_W-1:0]                    opcode,
   output logic [taint_filt_pkg::CODE_W-1:0]   code
);
   localparam int WORDS = 1 << ADDR_W;
   localparam int CW    = taint_filt_pkg::CODE_W;

   logic [CFG_DW-1:0] word_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q[w] <= '0;
         else if (we && addr == ADDR_W'(w))
            word_q[w] <= wdata;
      end
   end

   logic [ADDR_W-1:0] sel_word;
   logic [SLOT_W-1:0] sel_slot;

   assign sel_word = opcode[OPC_W-1:SLOT_W];
   assign sel_slot = opcode[SLOT_W-1:0];
   assign rdata    = word_q[addr];
   assign code     = word_q[sel_word][int'(sel_slot)*CW +: CW];

   // R2: a write is visible on the read port one cycle later
   assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata == $past(wdata)) || (addr != $past(addr)));
endmodule

// File: rtl/taint_filt_rules.sv
module taint_filt_rules #(
   parameter int ST_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  taint_filt_pkg::fcode_e code,
   input  logic [ST_W-1:0]       st_a,
   input  logic [ST_W-1:0]       st_b,
   input  logic [ST_W-1:0]       st_m,
   output logic                  hit,
   output logic [ST_W-1:0]       res
);
   import taint_filt_pkg::*;

   logic [NSRC-1:0][ST_W-1:0] src;
   logic [NSRC-1:0]           nz;
   logic [ST_W-1:0]           merged;
   logic                      none_nz;
   logic                      one_nz;

   assign src = {st_m, st_b, st_a};

   for (genvar i = 0; i < NSRC; i++) begin : g_nz
      assign nz[i] = |src[i];
   end

   always_comb begin
      merged = '0;
      for (int i = 0; i < NSRC; i++)
         merged = merged | src[i];
   end

   assign none_nz = (nz == '0);
   assign one_nz  = ($countones(nz) == 1);

   always_comb begin
      hit = 1'b0;
      res = '0;
      case (code)
         FC_ZERO:  hit = none_nz;
         FC_UNARY: begin
            hit = none_nz || one_nz;
            res = one_nz ? merged : '0;
         end
         default: ;
      endcase
   end

   // R5: the zero rule never yields a nonzero state
   assert_zero_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (code == FC_ZERO && hit) |-> (res == '0));
   // R6: a resolved unary result equals one of the inputs or is clean
   assert_unary_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (res == '0 || res == st_a || res == st_b || res == st_m));
endmodule

// File: rtl/taint_fast_filter.sv
module taint_fast_filter #(
   parameter int OPC_W  = 8,
   parameter int ST_W   = 2,
   parameter int CFG_DW = 32,
   localparam int SLOTS  = CFG_DW / taint_filt_pkg::CODE_W,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int ADDR_W = OPC_W - SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  op_code,
   input  logic [ST_W-1:0]   src_a_st,
   input  logic [ST_W-1:0]   src_b_st,
   input  logic [ST_W-1:0]   mem_st,
   input  logic              mem_use,
   output logic              hit,
   output logic [ST_W-1:0]   res_st,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [CFG_DW-1:0] cfg_rdata
);
   import taint_filt_pkg::*;

   if (CFG_DW % CODE_W != 0) begin : g_chk_dw
      $error("CFG_DW must be a multiple of the code width");
   end
   if ((1 << SLOT_W) != SLOTS) begin : g_chk_slots
      $error("codes per word must be a power of two");
   end
   if (OPC_W <= SLOT_W) begin : g_chk_opc
      $error("opcode must span more than one configuration word");
   end
   if (ST_W < 1 || ST_W > 16) begin : g_chk_st
      $error("taint state width must be 1 to 16");
   end

   logic [CODE_W-1:0] code_raw;
   fcode_e            code;
   logic [ST_W-1:0]   mem_eff;

   taint_filt_table #(
      .OPC_W (OPC_W),
      .CFG_DW(CFG_DW),
      .SLOT_W(SLOT_W),
      .ADDR_W(ADDR_W)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .opcode(op_code),
      .code  (code_raw)
   );

   assign code    = fcode_e'(code_raw);
   assign mem_eff = mem_use ? mem_st : '0;

   taint_filt_rules #(.ST_W(ST_W)) u_rules (
      .clk  (clk),
      .rst_n(rst_n),
      .code (code),
      .st_a (src_a_st),
      .st_b (src_b_st),
      .st_m (mem_eff),
      .hit  (hit),
      .res  (res_st)
   );

   // R3 and R4: disabled and reserved codes never resolve
   assert_no_hit_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_raw == 2'b00 || code_raw == 2'b11) |-> !hit);
   // R8: unresolved instructions carry a clean result
   assert_res_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (res_st == '0));
   // R7: an unused memory state cannot reach the result
   assert_mem_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !mem_use) |-> (res_st == '0 || res_st == src_a_st || res_st == src_b_st));
endmodule

// File: tb/taint_fast_filter_test.sv
module taint_fast_filter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_code = '0;
   logic [1:0]  src_a_st = '0, src_b_st = '0, mem_st = '0;
   logic        mem_use = 1'b0;
   logic        hit;
   logic [1:0]  res_st;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;

   taint_fast_filter uut (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .src_a_st(src_a_st),
      .src_b_st(src_b_st), .mem_st(mem_st), .mem_use(mem_use), .hit(hit),
      .res_st(res_st), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   always #10 clk = ~clk;

   typedef struct {
      bit          chk_flt;
      bit          exp_hit;
      logic [1:0]  exp_res;
      bit          chk_rd;
      logic [31:0] exp_rd;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   logic [1:0]  model[256];
   bit          done = 1'b0;

   // monitor: compare at the falling edge, half a cycle after inputs settle
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         if (it.chk_flt) begin
            n_chk++;
            if (hit !== it.exp_hit || res_st !== it.exp_res) begin
               n_fail++;
               $display("FAIL %s: hit/res = %0b/%0d, expected %0b/%0d",
                        it.tag, hit, res_st, it.exp_hit, it.exp_res);
            end
         end
         if (it.chk_rd) begin
            n_chk++;
            if (cfg_rdata !== it.exp_rd) begin
               n_fail++;
               $display("FAIL %s: rdata = %h, expected %h", it.tag, cfg_rdata, it.exp_rd);
            end
         end
      end
   end

   function automatic logic [31:0] word_of(input int k);
      logic [31:0] w = '0;
      for (int j = 0; j < 16; j++) w[2*j +: 2] = model[16*k + j];
      return w;
   endfunction

   task automatic set_code(input int op, input logic [1:0] c);
      model[op] = c;
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_addr = 4'(op / 16); cfg_wdata = word_of(op / 16);
      @(posedge clk); #2;
      cfg_we = 1'b0;
   endtask

   task automatic read_word(input int k, input string tag);
      item_t it;
      @(posedge clk); #2;
      cfg_addr = 4'(k);
      it = '{chk_flt: 0, exp_hit: 0, exp_res: 0, chk_rd: 1, exp_rd: word_of(k), tag: tag};
      sb_q.push_back(it);
   endtask

   task automatic apply(input int op, input logic [1:0] a, input logic [1:0] b,
                        input logic [1:0] m, input bit use_m, input string tag);
      item_t it;
      logic [1:0] me, orv;
      int cnt;
      bit eh;
      logic [1:0] er;
      me  = use_m ? m : 2'b00;
      cnt = (a != 0) + (b != 0) + (me != 0);
      orv = a | b | me;
      eh = 1'b0; er = 2'b00;
      case (model[op])
         2'b01: eh = (cnt == 0);
         2'b10: begin eh = (cnt <= 1); er = (cnt == 1) ? orv : 2'b00; end
         default: ;
      endcase
      @(posedge clk); #2;
      op_code = 8'(op); src_a_st = a; src_b_st = b; mem_st = m; mem_use = use_m;
      it = '{chk_flt: 1, exp_hit: eh, exp_res: er, chk_rd: 0, exp_rd: '0, tag: tag};
      sb_q.push_back(it);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) model[i] = 2'b00;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      for (int k = 0; k < 16; k++) read_word(k, "R1 reset word");
      apply(5, 2'd0, 2'd0, 2'd0, 1'b0, "R1 no hit after reset");
      apply(200, 2'd1, 2'd0, 2'd0, 1'b0, "R1 no hit after reset");

      // R2 / R9: configure and read back
      set_code(1, 2'b01);
      set_code(2, 2'b10);
      set_code(3, 2'b11);
      set_code(87, 2'b01);
      set_code(255, 2'b10);
      set_code(240, 2'b01);
      read_word(0, "R2 word 0 slots");
      read_word(5, "R2 word 5 slot 7");
      read_word(15, "R2 word 15 slots");
      for (int k = 1; k < 15; k++)
         if (k != 5) read_word(k, "R9 untouched word");

      // R3 / R4
      apply(0, 2'd0, 2'd0, 2'd0, 1'b0, "R3 code 00 clean");
      apply(0, 2'd2, 2'd0, 2'd0, 1'b0, "R3 code 00 single");
      apply(3, 2'd0, 2'd0, 2'd0, 1'b1, "R4 code 11 clean");
      apply(3, 2'd0, 2'd1, 2'd0, 1'b0, "R4 code 11 single");

      // R5 / R6 / R8 sweeps with memory used
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int m = 0; m < 4; m++) begin
               apply(1, 2'(a), 2'(b), 2'(m), 1'b1, "R5 zero rule sweep");
               apply(2, 2'(a), 2'(b), 2'(m), 1'b1, "R6 unary rule sweep");
            end

      // R7: memory state ignored when unused
      apply(1, 2'd0, 2'd0, 2'd2, 1'b0, "R7 zero rule mem masked");
      apply(2, 2'd1, 2'd0, 2'd3, 1'b0, "R7 unary mem masked");
      apply(2, 2'd0, 2'd0, 2'd3, 1'b0, "R7 unary all masked");
      apply(2, 2'd0, 2'd0, 2'd3, 1'b1, "R6 mem pass through");

      // R2 boundary opcodes, R8 cleanliness on miss
      apply(255, 2'd3, 2'd0, 2'd0, 1'b0, "R2 last opcode unary");
      apply(87, 2'd0, 2'd0, 2'd0, 1'b0, "R2 middle opcode zero");
      apply(240, 2'd0, 2'd0, 2'd0, 1'b1, "R2 first slot of last word");
      apply(241, 2'd0, 2'd0, 2'd0, 1'b1, "R9 neighbour slot off");
      apply(2, 2'd3, 2'd3, 2'd0, 1'b0, "R8 miss result clean");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule